// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Chopper

This block is the digital controller for one H-bridge winding. It receives a direction bit, a two-bit current-level select, a reference code, a sampled current-sense code and a die temperature code, and produces four enables: the high-side (source) and low-side (sink) switch of each half-bridge, A and B. While the bridge is on, current flows from A to B or from B to A, depending on the direction bit.

Current is regulated by slow-decay chopping. When the sense code reaches a threshold derived from the reference code and the select, the active source switch opens for a programmable off-time. The opposite sink stays closed, so the winding current recirculates and decays slowly. When the off-time ends, the source closes again. A programmable blanking window after each source turn-on hides turn-on spikes from the comparator. Every change of direction inserts a programmable dead time with all four switches open. The select code 11 opens all switches for fast decay. A temperature flag with hysteresis also forces all switches open.

Top module: `bridge_chopper`

## Requirements
- R1: While rst_ni is low, all four enables are 0.
- R2: With dir_i=1 the active pattern is src_a_o and snk_b_o high. With dir_i=0 it is src_b_o and snk_a_o high. The other two enables are low in both cases.
- R3: The trip condition depends on isel_i (bit 0 = I0, bit 1 = I1). For 2'b00 it is sense_i*10 >= ref_i. For 2'b01 it is sense_i*15 >= ref_i. For 2'b10 it is sense_i*30 >= ref_i. A trip sampled outside blanking opens the source at the following clock edge.
- R4: isel_i=2'b11 drives all four enables low from the next clock edge. Leaving 2'b11 turns the bridge on again one edge later.
- R5: After a trip, the source stays open for max(1, toff_i) cycles while the active sink stays closed. Then the source closes again.
- R6: A trip that occurs during the off-time does not lengthen it.
- R7: After each source turn-on, trips are masked for tblank_i cycles. With the trip held asserted, the source therefore stays closed for exactly tblank_i+1 cycles.
- R8: A change of dir_i opens all four enables for max(1, tdead_i) cycles, after which the new direction is driven. A further change during the dead time restarts it.
- R9: A temp_i code >= 170 opens all enables within two clock edges. They stay open until temp_i <= 145, and the bridge resumes two edges after that. A code of 169 has no effect.
- R10: No half-bridge ever has its source and sink enabled together. A sink of one direction is never followed in the next cycle by the sink of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Current direction, 1 = A to B |
| isel_i | input | 2 | Current-level select, bit 0 = I0, bit 1 = I1 |
| ref_i | input | REF_W | Reference code |
| sense_i | input | SENSE_W | Sampled sense-resistor code |
| temp_i | input | TEMP_W | Die temperature code in degrees |
| toff_i | input | CNT_W | Off-time in cycles |
| tdead_i | input | CNT_W | Dead time in cycles |
| tblank_i | input | CNT_W | Blanking time in cycles |
| src_a_o | output | 1 | High-side enable, half-bridge A |
| snk_a_o | output | 1 | Low-side enable, half-bridge A |
| src_b_o | output | 1 | High-side enable, half-bridge B |
| snk_b_o | output | 1 | Low-side enable, half-bridge B |

## Verification
With a reference code of 300, the sense code is stepped to one count below and then exactly onto each select's threshold. This separates the three multipliers and catches an off-by-one in the comparison. Single-cycle trip pulses measure the off-time. A second pulse placed inside the off-time shows whether a late trip extends it. A trip held high across the blanking window measures the masked span. Direction flips, including one inside the dead time, check both the gap and its restart. Temperature codes of 169, 170, 150 and 145 tell the two hysteresis edges apart from the band between them.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_DEAD, ST_ON, ST_CHOP} chop_state_e;

  localparam logic [1:0] ISEL_KILL = 2'b11;

  // threshold multiplier per select: ref/10, ref/15, ref/30
  function automatic logic [4:0] trip_mult(input logic [1:0] sel);
    case (sel)
      2'b00:   trip_mult = 5'd10;
      2'b01:   trip_mult = 5'd15;
      2'b10:   trip_mult = 5'd30;
      default: trip_mult = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/chop_thermal.sv
module chop_thermal #(
  parameter int TEMP_W  = 8,
  parameter int TEMP_HI = 170,
  parameter int TEMP_LO = 145
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);
  localparam logic [TEMP_W-1:0] HI = TEMP_W'(TEMP_HI);
  localparam logic [TEMP_W-1:0] LO = TEMP_W'(TEMP_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hot_o <= 1'b0;
    else if (temp_i >= HI) hot_o <= 1'b1;
    else if (temp_i <= LO) hot_o <= 1'b0;
  end
endmodule

// File: rtl/chop_trip.sv
module chop_trip
  import chop_pkg::*;
#(
  parameter int SENSE_W = 10,
  parameter int REF_W   = 10
) (
  input  logic [1:0]         isel_i,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic [REF_W-1:0]   ref_i,
  output logic               trip_o
);
  localparam int PW = SENSE_W + 5;
  localparam int CW = (PW > REF_W) ? PW : REF_W;

  logic [CW-1:0] prod, refx;

  always_comb begin
    prod   = CW'(sense_i) * CW'(trip_mult(isel_i));
    refx   = CW'(ref_i);
    trip_o = (isel_i != ISEL_KILL) && (prod >= refx);
  end
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_i,
  input  logic             dir_i,
  input  logic             trip_i,
  input  logic [CNT_W-1:0] toff_i,
  input  logic [CNT_W-1:0] tdead_i,
  input  logic [CNT_W-1:0] tblank_i,
  output logic             src_on_o,
  output logic             snk_on_o,
  output logic             dir_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  chop_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             flip;

  assign flip = dir_i != dir_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    if (kill_i) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_OFF: begin
          state_d = ST_ON;
          dir_d   = dir_i;
          cnt_d   = tblank_i;
        end
        ST_DEAD: begin
          if (flip) begin
            dir_d = dir_i;
            cnt_d = tdead_i;
          end else if (cnt_q <= ONE) begin
            state_d = ST_ON;
            cnt_d   = tblank_i;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        ST_ON: begin
          if (flip) begin
            state_d = ST_DEAD;
            dir_d   = dir_i;
            cnt_d   = tdead_i;
          end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;    // blanking
          end else if (trip_i) begin
            state_d = ST_CHOP;
            cnt_d   = toff_i;
          end
        end
        default: begin              // ST_CHOP, trips ignored
          if (flip) begin
            state_d = ST_DEAD;
            dir_d   = dir_i;
            cnt_d   = tdead_i;
          end else if (cnt_q <= ONE) begin
            state_d = ST_ON;
            cnt_d   = tblank_i;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
    end
  end

  assign src_on_o = state_q == ST_ON;
  assign snk_on_o = (state_q == ST_ON) || (state_q == ST_CHOP);
  assign dir_o    = dir_q;
endmodule

// File: rtl/bridge_chopper.sv
module bridge_chopper
  import chop_pkg::*;
#(
  parameter int SENSE_W = 10,
  parameter int REF_W   = 10,
  parameter int TEMP_W  = 8,
  parameter int CNT_W   = 12,
  parameter int TEMP_HI = 170,
  parameter int TEMP_LO = 145
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dir_i,
  input  logic [1:0]         isel_i,
  input  logic [REF_W-1:0]   ref_i,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic [CNT_W-1:0]   toff_i,
  input  logic [CNT_W-1:0]   tdead_i,
  input  logic [CNT_W-1:0]   tblank_i,
  output logic               src_a_o,
  output logic               snk_a_o,
  output logic               src_b_o,
  output logic               snk_b_o
);
  localparam int LEGS = 2;

  logic            hot, trip, kill, src_on, snk_on, dir_q;
  logic [LEGS-1:0] src_leg, snk_leg;

  chop_thermal #(.TEMP_W(TEMP_W), .TEMP_HI(TEMP_HI), .TEMP_LO(TEMP_LO)) u_therm (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_i), .hot_o(hot)
  );

  chop_trip #(.SENSE_W(SENSE_W), .REF_W(REF_W)) u_trip (
    .isel_i(isel_i), .sense_i(sense_i), .ref_i(ref_i), .trip_o(trip)
  );

  assign kill = hot || (isel_i == ISEL_KILL);

  chop_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .kill_i(kill), .dir_i(dir_i), .trip_i(trip),
    .toff_i(toff_i), .tdead_i(tdead_i), .tblank_i(tblank_i),
    .src_on_o(src_on), .snk_on_o(snk_on), .dir_o(dir_q)
  );

  // leg 0 = A sources when dir high, leg 1 = B sources when dir low
  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    localparam logic SRC_DIR = (l == 0);
    assign src_leg[l] = src_on && (dir_q == SRC_DIR);
    assign snk_leg[l] = snk_on && (dir_q != SRC_DIR);
  end

  assign src_a_o = src_leg[0];
  assign snk_a_o = snk_leg[0];
  assign src_b_o = src_leg[1];
  assign snk_b_o = snk_leg[1];
endmodule

// File: rtl/chop_checker.sv
module chop_checker #(
  parameter int TEMP_W  = 8,
  parameter int TEMP_HI = 170
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        isel_i,
  input logic [TEMP_W-1:0] temp_i,
  input logic              src_a_o,
  input logic              snk_a_o,
  input logic              src_b_o,
  input logic              snk_b_o
);
  localparam logic [TEMP_W-1:0] HI = TEMP_W'(TEMP_HI);

  logic [3:0] drv;
  assign drv = {src_a_o, snk_a_o, src_b_o, snk_b_o};

  always_comb begin
    if (!rst_ni) p_reset_off_r1: assert (drv == 4'b0000);
  end

  p_leg_a_safe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_a_o && snk_a_o));
  p_leg_b_safe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_b_o && snk_b_o));
  p_one_source_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({src_a_o, src_b_o}));
  p_src_pairs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_o |-> snk_b_o) and (src_b_o |-> snk_a_o));
  p_dead_ab_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_b_o |=> !snk_a_o);
  p_dead_ba_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_a_o |=> !snk_b_o);
  p_kill_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isel_i == 2'b11) |=> (drv == 4'b0000));
  p_hot_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= HI) |=> ##1 (drv == 4'b0000));
endmodule

bind bridge_chopper chop_checker #(.TEMP_W(TEMP_W), .TEMP_HI(TEMP_HI)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .isel_i(isel_i), .temp_i(temp_i),
  .src_a_o(src_a_o), .snk_a_o(snk_a_o), .src_b_o(src_b_o), .snk_b_o(snk_b_o)
);

// File: tb/sim_bridge_chopper.sv
module sim_bridge_chopper;
  localparam int CLK_P = 10;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dir = 1'b1;
  logic [1:0]       isel = 2'b00;
  logic [9:0]       ref_c = 10'd300;
  logic [9:0]       sense = '0;
  logic [7:0]       temp = 8'd25;
  logic [CNT_W-1:0] toff = 12'd6, tdead = 12'd4, tblank = 12'd0;
  logic src_a, snk_a, src_b, snk_b;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bridge_chopper u0 (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .isel_i(isel), .ref_i(ref_c),
    .sense_i(sense), .temp_i(temp), .toff_i(toff), .tdead_i(tdead), .tblank_i(tblank),
    .src_a_o(src_a), .snk_a_o(snk_a), .src_b_o(src_b), .snk_b_o(snk_b)
  );

  task automatic step();
    @(negedge clk);
  endtask

  // vector order {src_a, snk_a, src_b, snk_b}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {src_a, snk_a, src_b, snk_b};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: drivers=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset_dir();
    repeat (3) step();
    chk("R1 reset", 4'b0000);
    rst_n = 1'b1;
    step();
    chk("R2 dir high", 4'b1001);
  endtask

  task automatic t_thresh(input logic [1:0] sel, input logic [9:0] below, input logic [9:0] at);
    isel = sel;
    sense = '0;
    repeat (10) step();
    sense = below;
    repeat (3) begin
      step();
      chk("R3 below threshold", 4'b1001);
    end
    sense = at;
    step();
    chk("R3 at threshold", 4'b0001);
    sense = '0;
    repeat (10) step();
  endtask

  task automatic t_offtime();
    isel = 2'b00;
    sense = '0;
    repeat (10) step();
    chk("R5 on before trip", 4'b1001);
    sense = 10'd30;
    step();
    sense = '0;
    for (int i = 0; i < 6; i++) begin
      chk("R5 off-time", 4'b0001);
      if (i == 2) sense = 10'd30;
      if (i == 3) sense = '0;
      step();
    end
    chk("R6 late trip ignored", 4'b1001);
    repeat (10) step();
  endtask

  task automatic t_blank();
    int k, n;
    tblank = 12'd4;
    toff = 12'd3;
    sense = '0;
    repeat (10) step();
    sense = 10'd30;
    step();
    chk("R7 first trip", 4'b0001);
    k = 0;
    while (!src_a && k < 20) begin step(); k++; end
    n = 0;
    while (src_a && n < 20) begin n++; step(); end
    chk_int("R7 blanked on-span", n, 5);
    chk("R7 chop after blank", 4'b0001);
    sense = '0;
    tblank = 12'd0;
    toff = 12'd6;
    repeat (10) step();
  endtask

  task automatic t_dead();
    chk("R2 on before flip", 4'b1001);
    dir = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R8 R10 dead gap", 4'b0000);
    end
    step();
    chk("R2 dir low", 4'b0110);
    dir = 1'b1;
    step();
    chk("R8 dead on flip back", 4'b0000);
    dir = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R8 dead restart", 4'b0000);
    end
    step();
    chk("R8 after restart", 4'b0110);
    dir = 1'b1;
    repeat (10) step();
    chk("R2 dir high again", 4'b1001);
  endtask

  task automatic t_disable();
    isel = 2'b11;
    sense = 10'd30;
    step();
    chk("R4 select 11 off", 4'b0000);
    repeat (3) step();
    chk("R4 stays off", 4'b0000);
    isel = 2'b00;
    sense = '0;
    step();
    chk("R4 resume", 4'b1001);
    repeat (5) step();
  endtask

  task automatic t_thermal();
    temp = 8'd169;
    repeat (3) step();
    chk("R9 169 no effect", 4'b1001);
    temp = 8'd170;
    step();
    step();
    chk("R9 hot off", 4'b0000);
    temp = 8'd150;
    repeat (4) step();
    chk("R9 hysteresis band", 4'b0000);
    temp = 8'd145;
    step();
    step();
    chk("R9 cooled resume", 4'b1001);
  endtask

  initial begin
    t_reset_dir();
    t_thresh(2'b00, 10'd29, 10'd30);
    t_thresh(2'b01, 10'd19, 10'd20);
    t_thresh(2'b10, 10'd9, 10'd10);
    t_offtime();
    t_blank();
    t_dead();
    t_disable();
    t_thermal();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule